// File: doc/BRIEF.md
# Dual-Mode Command Latch Interface

This block accepts an 8-bit command word from a host microcontroller and holds it in internal latches. The word carries a 6-bit tone code, a receive/transmit select bit and a press-to-listen bit. The host can send it over a parallel pin bus or over a three-wire serial link. The serial link is made from the same pins, which change role with the mode. A single load/latch control decides when the latches take new data.

All external pins are asynchronous to the block. Each one passes through a two-flop synchroniser into one fast system clock. Edges on the serial clock and on load/latch are found in that clock domain. The host drives the pins directly. There is no handshake. The latched fields are plain level outputs that stay valid until the next accepted load. A consumer reads them whenever it needs them and cannot apply back-pressure.

Pin bus layout (`pins_i`): bit 7 is D5, bit 6 is D4, bits 7..2 are D5..D0, bit 1 is the rx_tx data pin and bit 0 is the ptl data pin. Serial mode is active while bit 7 is 1 and bit 6 is 0. In serial mode, bit 5 (D3) carries the data and bit 4 (D2) is the serial clock.

Top module: `cmd_latch_if`

## Requirements
- R1: During and after reset, before any pin changes, the outputs read all ones: tone code 6'h3F, rx_tx 1 and ptl 1. This matches pins that are left undriven and pulled up.
- R2: In parallel mode with load/latch high, the outputs follow the bus. `pins_i[7:2]` drives the tone code, `pins_i[1]` drives rx_tx and `pins_i[0]` drives ptl.
- R3: In parallel mode, a high-to-low step on load/latch captures the word. While load/latch stays low, later bus changes have no effect.
- R4: While `pins_i[7]`=1 and `pins_i[6]`=0 (serial mode), bus values are never passed through transparently. With load/latch held high and no falling step, the outputs do not change.
- R5: In serial mode, `pins_i[5]` is sampled on each rising step of `pins_i[4]`. The first bit shifted in lands on tone code bit 5 and the eighth lands on ptl.
- R6: In serial mode, the shifted word reaches the outputs only after a complete low-high-low pulse on load/latch. The rising step alone changes nothing.
- R7: If more or fewer than 8 bits are clocked in before the strobe, the strobe loads the last 8 bits shifted in. Older shift contents fill the word when fewer than 8 new bits arrive.
- R8: `pins_i[3:2]` (D1, D0) have no effect while serial mode is active.
- R9: A bus change in transparent parallel mode reaches the outputs on the third rising system-clock edge after it is applied, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_latch_i | input | 1 | Load/latch control pin (high = transparent / strobe high) |
| pins_i | input | 8 | D5..D0, rx_tx and ptl data pins, shared with the serial select, data and clock roles |
| tone_code_o | output | 6 | Latched tone code |
| rx_tx_o | output | 1 | Latched receive/transmit select |
| ptl_o | output | 1 | Latched press-to-listen bit |

## Verification
The assertions assume that the host holds each pin level for several system-clock cycles. As a result, every serial clock level, data bit and strobe level is seen by the synchroniser and the edge detectors. They also assume that the two mode-select pins change together and settle before any strobe. The stimulus holds every pin change for at least three cycles. It changes the serial data a full phase before its clock edge, and it switches mode only while load/latch is low.

// File: rtl/cmd_if_pkg.sv
package cmd_if_pkg;
  localparam int TONE_W = 6;
  localparam int WORD_W = TONE_W + 2;

  typedef struct packed {
    logic [TONE_W-1:0] tone;
    logic              rx_tx;
    logic              ptl;
  } cmd_word_t;
endpackage

// File: rtl/cmd_sync.sv
module cmd_sync #(
  parameter int   W       = 1,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= {W{RST_VAL}};
        else        stage_q[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= {W{RST_VAL}};
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/cmd_edge_det.sv
module cmd_edge_det #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;
endmodule

// File: rtl/cmd_serial_shift.sv
module cmd_serial_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         bit_i,
  output logic [W-1:0] word_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sr_q <= '0;
    else if (shift_en) sr_q <= {sr_q[W-2:0], bit_i};
  end

  assign word_o = sr_q;
endmodule

// File: rtl/cmd_latch_ctrl.sv
module cmd_latch_ctrl #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ser_mode,
  input  logic         ll_lvl,
  input  logic         ll_rise,
  input  logic         ll_fall,
  input  logic [W-1:0] par_word,
  input  logic [W-1:0] ser_word,
  output logic [W-1:0] latch_q,
  output logic         armed_o
);
  logic armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '1;
      armed_q <= 1'b0;
    end else if (!ser_mode) begin
      armed_q <= 1'b0;
      if (ll_lvl) latch_q <= par_word;
    end else if (ll_rise) begin
      armed_q <= 1'b1;
    end else if (ll_fall) begin
      armed_q <= 1'b0;
      if (armed_q) latch_q <= ser_word;
    end
  end

  assign armed_o = armed_q;
endmodule

// File: rtl/cmd_latch_if.sv
module cmd_latch_if
  import cmd_if_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_latch_i,
  input  logic [WORD_W-1:0] pins_i,
  output logic [TONE_W-1:0] tone_code_o,
  output logic              rx_tx_o,
  output logic              ptl_o
);
  localparam int SEL_HI = WORD_W - 1;
  localparam int SEL_LO = WORD_W - 2;
  localparam int SDATA  = WORD_W - 3;
  localparam int SCLK   = WORD_W - 4;

  logic [WORD_W-1:0] bus_s;
  logic              ll_s;
  logic              ll_rise, ll_fall;
  logic              sclk_rise, sclk_fall;
  logic              ser_mode;
  logic [WORD_W-1:0] par_word, ser_word, latch_q;
  logic              armed;
  cmd_word_t         cmd;

  cmd_sync #(.W(WORD_W), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_bus_sync (
    .clk(clk), .rst_n(rst_n), .d(pins_i), .q(bus_s));

  cmd_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ll_sync (
    .clk(clk), .rst_n(rst_n), .d(load_latch_i), .q(ll_s));

  cmd_edge_det #(.RST_VAL(1'b1)) u_ll_edge (
    .clk(clk), .rst_n(rst_n), .lvl(ll_s), .rise(ll_rise), .fall(ll_fall));

  cmd_edge_det #(.RST_VAL(1'b1)) u_sclk_edge (
    .clk(clk), .rst_n(rst_n), .lvl(bus_s[SCLK]), .rise(sclk_rise), .fall(sclk_fall));

  assign ser_mode = bus_s[SEL_HI] & ~bus_s[SEL_LO];
  assign par_word = bus_s;

  cmd_serial_shift #(.W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .shift_en(ser_mode & sclk_rise),
    .bit_i(bus_s[SDATA]), .word_o(ser_word));

  cmd_latch_ctrl #(.W(WORD_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .ser_mode(ser_mode), .ll_lvl(ll_s),
    .ll_rise(ll_rise), .ll_fall(ll_fall), .par_word(par_word),
    .ser_word(ser_word), .latch_q(latch_q), .armed_o(armed));

  assign cmd         = cmd_word_t'(latch_q);
  assign tone_code_o = cmd.tone;
  assign rx_tx_o     = cmd.rx_tx;
  assign ptl_o       = cmd.ptl;

  logic unused_sclk_fall;
  assign unused_sclk_fall = sclk_fall;
endmodule

// File: rtl/cmd_latch_if_chk.sv
module cmd_latch_if_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ser_mode,
  input logic         ll_s,
  input logic         ll_fall,
  input logic         armed,
  input logic         sclk_rise,
  input logic [W-1:0] par_word,
  input logic [W-1:0] ser_word,
  input logic [W-1:0] latch_q
);
  assert_reset_ones_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (latch_q == '1));

  assert_par_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_mode && ll_s) |=> (latch_q == $past(par_word)));

  assert_hold_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(ll_s) && !$past(ll_s, 2)) |-> $stable(latch_q));

  assert_ser_no_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_mode && !ll_fall) |=> $stable(latch_q));

  assert_shift_on_clk_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(ser_mode && sclk_rise) |=> $stable(ser_word));

  assert_strobe_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_mode && ll_fall && armed) |=> (latch_q == $past(ser_word)));
endmodule

bind cmd_latch_if cmd_latch_if_chk #(.W(cmd_if_pkg::WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ser_mode(ser_mode), .ll_s(ll_s),
  .ll_fall(ll_fall), .armed(armed), .sclk_rise(sclk_rise),
  .par_word(par_word), .ser_word(ser_word), .latch_q(latch_q));

// File: tb/tb_cmd_latch_if.sv
module tb_cmd_latch_if;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ll = 1'b1;
  logic [7:0] par_val = 8'hFF;
  logic       ser_on = 1'b0;
  logic       sdat = 1'b0, sclk = 1'b0;
  logic [1:0] d10 = 2'b00;
  logic [7:0] pins;
  logic [5:0] tone;
  logic       rx_tx, ptl;

  typedef struct { logic [7:0] word; string tag; } exp_t;
  exp_t exp_q[$];
  event push_ev;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  assign pins = ser_on ? {2'b10, sdat, sclk, d10, 2'b00} : par_val;

  cmd_latch_if dut (
    .clk(clk), .rst_n(rst_n), .load_latch_i(ll), .pins_i(pins),
    .tone_code_o(tone), .rx_tx_o(rx_tx), .ptl_o(ptl));

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_word(input logic [7:0] w, input string tag);
    exp_t e;
    e.word = w;
    e.tag  = tag;
    exp_q.push_back(e);
    -> push_ev;
  endtask

  task automatic send_bits(input logic [10:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdat = bits[i];
      d10  = d10 + 2'd1;
      cyc(3);
      sclk = 1'b1;
      cyc(3);
      sclk = 1'b0;
      d10  = ~d10;
      cyc(3);
    end
  endtask

  task automatic strobe();
    ll = 1'b1;
    cyc(4);
    ll = 1'b0;
    cyc(5);
  endtask

  initial begin : monitor
    forever begin
      @(push_ev);
      #1;
      while (exp_q.size() > 0) begin
        exp_t e;
        logic [7:0] act;
        e = exp_q.pop_front();
        act = {tone, rx_tx, ptl};
        checks++;
        if (act !== e.word) begin
          failures++;
          $display("FAIL %s: actual=%h expected=%h", e.tag, act, e.word);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : driver
    cyc(2);
    expect_word(8'hFF, "R1 in reset");
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
    expect_word(8'hFF, "R1 after reset");

    par_val = 8'h4B; cyc(5);
    expect_word(8'h4B, "R2 transparent a");
    par_val = 8'hC6; cyc(5);
    expect_word(8'hC6, "R2 transparent b");

    par_val = 8'h3A;
    @(posedge clk); @(posedge clk); @(negedge clk);
    expect_word(8'hC6, "R9 not before third edge");
    @(posedge clk); @(negedge clk);
    expect_word(8'h3A, "R9 on third edge");

    ll = 1'b0; cyc(5);
    par_val = 8'h11; cyc(5);
    expect_word(8'h3A, "R3 hold after fall a");
    par_val = 8'h22; cyc(5);
    expect_word(8'h3A, "R3 hold after fall b");

    ser_on = 1'b1; cyc(5);
    send_bits(11'h0A5, 8);
    expect_word(8'h3A, "R4 no load before strobe");
    ll = 1'b1; cyc(6);
    expect_word(8'h3A, "R4 no pass-through with strobe high");
    ll = 1'b0; cyc(5);
    expect_word(8'hA5, "R5 serial word first");

    send_bits(11'h05C, 8);
    strobe();
    expect_word(8'h5C, "R5 serial word second");

    send_bits(11'h096, 8);
    d10 = 2'b11; cyc(5);
    d10 = 2'b01; cyc(5);
    strobe();
    expect_word(8'h96, "R8 D1 D0 ignored in serial");

    send_bits(11'b101_0011_1100, 11);
    strobe();
    expect_word(8'h3C, "R7 eleven bits keep last eight");
    send_bits(11'b011, 3);
    strobe();
    expect_word(8'hE3, "R7 three bits merge with older");

    send_bits(11'h00F, 8);
    ll = 1'b1; cyc(6);
    expect_word(8'hE3, "R6 rising step alone");
    ll = 1'b0; cyc(5);
    expect_word(8'h0F, "R6 full pulse loads");

    ser_on = 1'b0;
    par_val = 8'h40; cyc(5);
    expect_word(8'h0F, "R3 parallel hold after serial");
    ll = 1'b1; cyc(5);
    expect_word(8'h40, "R2 transparent after serial");

    cyc(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule